// File: doc/BRIEF.md
# Ring Buffer Pointer Tracker with Watermark Interrupt

This block follows one audio ring buffer held in external memory. It holds the buffer's start and last byte addresses, a read pointer and a write pointer, and from these it derives the filled byte count, the full and empty flags and the current position offset. The engine that moves the audio data reports each transfer with an advance strobe and a byte count. The tracker moves the matching pointer, wraps it at the end of the buffer and refuses any transfer that would read more than the buffer holds or write more than it has room for.

Each pointer is 32 bits wide. Bits 30:0 are a byte address and bit 31 flips on every wrap. Equal pointers mean empty. Equal addresses with different bit 31 mean full. A parameter selects the direction. In the playback variant the watermark measures free space. In the capture variant it measures filled space. The interrupt pulses once when the measure strictly exceeds the programmed mark. It then stays quiet until software re-arms it.

Software programs the block through a simple write port: a select code, a data word and a write enable. Reads go straight to the pointer, level and offset outputs.

Top module: `rbuf_ptr_tracker`

## Requirements
- R1: `empty` is 1 exactly when `rd_ptr` equals `wr_ptr` in all 32 bits. `full` is 1 exactly when bits 30:0 are equal and bit 31 differs.
- R2: `level` gives the filled byte count. With equal bit 31 it is wr address minus rd address. Otherwise it is the size (end minus base plus 1) minus (rd address minus wr address).
- R3: An accepted advance adds its byte count to the pointer's address bits. If the sum passes the end address, the buffer size is subtracted and bit 31 is inverted. The new value appears one cycle after the strobe.
- R4: A read advance whose count exceeds `level` is refused. `rd_ptr` stays unchanged and `underflow_evt` pulses for one cycle, in the same cycle the pointer would have changed.
- R5: A write advance whose count exceeds the free space (size minus `level`) is refused. `wr_ptr` stays unchanged and `overflow_evt` pulses for one cycle.
- R6: A register write with `cfg_we`=1 takes effect in the next cycle. The select codes are 0 = base, 1 = end, 2 = mark, 3 = read pointer and 4 = write pointer; codes 5 to 7 do nothing. A pointer write wins over an advance of the same pointer in the same cycle.
- R7: In the capture variant (IS_PLAYBACK=0), `mark_irq` pulses for one cycle when `level` becomes strictly greater than the mark. A level equal to the mark does not fire.
- R8: In the playback variant (IS_PLAYBACK=1), the measure is the free space and the same strict comparison applies.
- R9: Once the interrupt has fired it is disarmed, and it fires no more until `mark_rearm` is pulsed. The watermark is also disarmed out of reset.
- R10: `pos_offset` is the address bits (30:0) of the active pointer minus the base address. The active pointer is the read pointer for playback and the write pointer for capture.
- R11: After reset, both pointers, base, end and mark are 0, `empty`=1, `level`=0, and all pulse outputs are 0.
- R12: The stored mark keeps only multiples of MARK_GRAN (256 by default). The low bits of a written mark value are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select (0 base, 1 end, 2 mark, 3 rd ptr, 4 wr ptr) |
| cfg_wdata | input | PTR_W | Register write data |
| mark_rearm | input | 1 | Re-arm strobe for the watermark |
| rd_adv | input | 1 | Read advance strobe from the data engine |
| rd_bytes | input | CNT_W | Bytes consumed by the read advance |
| wr_adv | input | 1 | Write advance strobe from the data engine |
| wr_bytes | input | CNT_W | Bytes produced by the write advance |
| rd_ptr | output | PTR_W | Read pointer with wrap bit |
| wr_ptr | output | PTR_W | Write pointer with wrap bit |
| level | output | PTR_W | Filled byte count |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| pos_offset | output | PTR_W-1 | Active pointer offset from base |
| mark_irq | output | 1 | One-cycle watermark interrupt pulse |
| underflow_evt | output | 1 | Refused read advance pulse |
| overflow_evt | output | 1 | Refused write advance pulse |

## Verification
A wrong wrap bit inverts the empty and full flags and flips `level` between 0 and the full size. This shows on the ports in the cycle after the advance that caused it. A stuck or stale arm flag shows as a missing or repeated `mark_irq`, one cycle after the level crosses the mark or the re-arm arrives. The bench therefore counts interrupt pulses over windows around each crossing. A wrong fill count also shows up one cycle later in a guard decision: a transfer that should be refused is accepted, or the reverse. The bench steers pointers to the exact boundaries, so a wrong decision flips an event pulse and leaves a pointer at the wrong value.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
   typedef enum logic [2:0] {
      SEL_BASE = 3'd0,
      SEL_END  = 3'd1,
      SEL_MARK = 3'd2,
      SEL_RD   = 3'd3,
      SEL_WR   = 3'd4
   } cfg_sel_e;

   localparam int MIN_MARK_GRAN = 256;
endpackage

// File: rtl/rbuf_ptr_step.sv
// Next pointer value for an advance: add the byte count, wrap at end, flip bit 31.
module rbuf_ptr_step #(
   parameter int PTR_W = 32,
   parameter int CNT_W = 16
) (
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [CNT_W-1:0] bytes_i,
   input  logic [PTR_W-2:0] base_i,
   input  logic [PTR_W-2:0] end_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam int AW = PTR_W - 1;

   logic [PTR_W-1:0] sum;
   logic [PTR_W-1:0] size;
   logic [PTR_W-1:0] folded;

   always_comb begin
      sum    = {1'b0, ptr_i[AW-1:0]} + PTR_W'(bytes_i);
      size   = {1'b0, end_i} - {1'b0, base_i} + PTR_W'(1);
      folded = sum - size;
      if (sum > {1'b0, end_i})
         ptr_o = {~ptr_i[AW], folded[AW-1:0]};
      else
         ptr_o = {ptr_i[AW], sum[AW-1:0]};
   end
endmodule

// File: rtl/rbuf_level.sv
// Fill count, free space and full/empty flags from the two wrap-tagged pointers.
module rbuf_level #(
   parameter int PTR_W = 32
) (
   input  logic [PTR_W-1:0] rd_i,
   input  logic [PTR_W-1:0] wr_i,
   input  logic [PTR_W-2:0] base_i,
   input  logic [PTR_W-2:0] end_i,
   output logic [PTR_W-1:0] fill_o,
   output logic [PTR_W-1:0] free_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int AW = PTR_W - 1;

   logic             same_lap;
   logic [PTR_W-1:0] size;
   logic [PTR_W-1:0] rd_a;
   logic [PTR_W-1:0] wr_a;

   always_comb begin
      rd_a     = {1'b0, rd_i[AW-1:0]};
      wr_a     = {1'b0, wr_i[AW-1:0]};
      same_lap = (rd_i[AW] == wr_i[AW]);
      size     = {1'b0, end_i} - {1'b0, base_i} + PTR_W'(1);
      fill_o   = same_lap ? (wr_a - rd_a) : (size - (rd_a - wr_a));
      free_o   = size - fill_o;
      empty_o  = (rd_i == wr_i);
      full_o   = (rd_a == wr_a) && !same_lap;
   end
endmodule

// File: rtl/rbuf_mark.sv
// One-shot watermark: fires when the measure strictly exceeds the mark, then waits for re-arm.
module rbuf_mark #(
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] measure_i,
   input  logic [PTR_W-2:0] mark_i,
   input  logic             rearm_i,
   output logic             irq_o
);
   logic armed_q;
   logic fire;

   assign fire = armed_q && (measure_i > {1'b0, mark_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         armed_q <= (armed_q && !fire) || rearm_i;
         irq_o   <= fire;
      end
   end
endmodule

// File: rtl/rbuf_ptr_tracker.sv
module rbuf_ptr_tracker
   import rbuf_pkg::*;
#(
   parameter int PTR_W       = 32,
   parameter int CNT_W       = 16,
   parameter int MARK_GRAN   = 256,
   parameter bit IS_PLAYBACK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [PTR_W-1:0] cfg_wdata,
   input  logic             mark_rearm,
   input  logic             rd_adv,
   input  logic [CNT_W-1:0] rd_bytes,
   input  logic             wr_adv,
   input  logic [CNT_W-1:0] wr_bytes,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic [PTR_W-2:0] pos_offset,
   output logic             mark_irq,
   output logic             underflow_evt,
   output logic             overflow_evt
);
   localparam int AW = PTR_W - 1;
   localparam logic [AW-1:0] GRAN_MASK = ~AW'(MARK_GRAN - 1);

   generate
      if (MARK_GRAN < MIN_MARK_GRAN || (MARK_GRAN & (MARK_GRAN - 1)) != 0)
         $error("MARK_GRAN must be a power of two of at least 256");
      if (CNT_W > AW || PTR_W < 10)
         $error("CNT_W must fit in the address bits and PTR_W must be at least 10");
   endgenerate

   logic [AW-1:0]    base_q, end_q, mark_q;
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [PTR_W-1:0] rd_next, wr_next;
   logic [PTR_W-1:0] fill, free_sp, measure, active_ptr;
   logic             sw_rd, sw_wr, rd_ok, wr_ok;
   logic             unf_q, ovf_q;
   cfg_sel_e         sel;

   assign sel   = cfg_sel_e'(cfg_sel);
   assign sw_rd = cfg_we && (sel == SEL_RD);
   assign sw_wr = cfg_we && (sel == SEL_WR);
   assign rd_ok = PTR_W'(rd_bytes) <= fill;
   assign wr_ok = PTR_W'(wr_bytes) <= free_sp;

   rbuf_ptr_step #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_rd_step (
      .ptr_i(rd_q), .bytes_i(rd_bytes), .base_i(base_q), .end_i(end_q), .ptr_o(rd_next));

   rbuf_ptr_step #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_wr_step (
      .ptr_i(wr_q), .bytes_i(wr_bytes), .base_i(base_q), .end_i(end_q), .ptr_o(wr_next));

   rbuf_level #(.PTR_W(PTR_W)) u_level (
      .rd_i(rd_q), .wr_i(wr_q), .base_i(base_q), .end_i(end_q),
      .fill_o(fill), .free_o(free_sp), .full_o(full), .empty_o(empty));

   generate
      if (IS_PLAYBACK) begin : g_play
         assign measure    = free_sp;
         assign active_ptr = rd_q;
      end else begin : g_capt
         assign measure    = fill;
         assign active_ptr = wr_q;
      end
   endgenerate

   rbuf_mark #(.PTR_W(PTR_W)) u_mark (
      .clk(clk), .rst_n(rst_n), .measure_i(measure), .mark_i(mark_q),
      .rearm_i(mark_rearm), .irq_o(mark_irq));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         end_q  <= '0;
         mark_q <= '0;
         rd_q   <= '0;
         wr_q   <= '0;
         unf_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         unf_q <= 1'b0;
         ovf_q <= 1'b0;
         if (cfg_we && sel == SEL_BASE) base_q <= cfg_wdata[AW-1:0];
         if (cfg_we && sel == SEL_END)  end_q  <= cfg_wdata[AW-1:0];
         if (cfg_we && sel == SEL_MARK) mark_q <= cfg_wdata[AW-1:0] & GRAN_MASK;
         if (sw_rd)
            rd_q <= cfg_wdata;
         else if (rd_adv) begin
            if (rd_ok) rd_q  <= rd_next;
            else       unf_q <= 1'b1;
         end
         if (sw_wr)
            wr_q <= cfg_wdata;
         else if (wr_adv) begin
            if (wr_ok) wr_q  <= wr_next;
            else       ovf_q <= 1'b1;
         end
      end
   end

   assign rd_ptr        = rd_q;
   assign wr_ptr        = wr_q;
   assign level         = fill;
   assign pos_offset    = active_ptr[AW-1:0] - base_q;
   assign underflow_evt = unf_q;
   assign overflow_evt  = ovf_q;
endmodule

// File: rtl/rbuf_ptr_tracker_chk.sv
module rbuf_ptr_tracker_chk #(
   parameter int PTR_W = 32,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [2:0]       cfg_sel,
   input logic [PTR_W-1:0] cfg_wdata,
   input logic             mark_rearm,
   input logic             rd_adv,
   input logic [CNT_W-1:0] rd_bytes,
   input logic             wr_adv,
   input logic [CNT_W-1:0] wr_bytes,
   input logic [PTR_W-1:0] rd_ptr,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [PTR_W-1:0] level,
   input logic             full,
   input logic             empty,
   input logic             mark_irq,
   input logic             underflow_evt,
   input logic             overflow_evt,
   input logic [PTR_W-2:0] base_q,
   input logic [PTR_W-2:0] end_q
);
   logic [PTR_W-1:0] size;
   logic             sw_rd, sw_wr;

   assign size  = {1'b0, end_q} - {1'b0, base_q} + PTR_W'(1);
   assign sw_rd = cfg_we && (cfg_sel == 3'd3);
   assign sw_wr = cfg_we && (cfg_sel == 3'd4);

   assert_empty_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (level == '0 && rd_ptr == wr_ptr));

   assert_full_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (level == size));

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_adv && !sw_rd && PTR_W'(rd_bytes) > level) |=> (underflow_evt && $stable(rd_ptr)));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_adv && !sw_wr && PTR_W'(wr_bytes) > (size - level)) |=> (overflow_evt && $stable(wr_ptr)));

   assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rd |=> (rd_ptr == $past(cfg_wdata)));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_irq && !$past(mark_rearm)) |=> !mark_irq);
endmodule

bind rbuf_ptr_tracker rbuf_ptr_tracker_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
   .mark_rearm(mark_rearm), .rd_adv(rd_adv), .rd_bytes(rd_bytes), .wr_adv(wr_adv),
   .wr_bytes(wr_bytes), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .level(level), .full(full),
   .empty(empty), .mark_irq(mark_irq), .underflow_evt(underflow_evt),
   .overflow_evt(overflow_evt), .base_q(base_q), .end_q(end_q));

// File: tb/rbuf_ptr_tracker_test.sv
`timescale 1ns/1ps
module rbuf_ptr_tracker_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // capture instance stimulus
   logic        c_we = 0, c_rearm = 0, c_rd = 0, c_wr = 0;
   logic [2:0]  c_sel = 0;
   logic [31:0] c_data = 0;
   logic [15:0] c_rb = 0, c_wb = 0;
   logic [31:0] c_rptr, c_wptr, c_lvl;
   logic        c_full, c_empty, c_irq, c_unf, c_ovf;
   logic [30:0] c_pos;

   // playback instance stimulus
   logic        p_we = 0, p_rearm = 0, p_rd = 0, p_wr = 0;
   logic [2:0]  p_sel = 0;
   logic [31:0] p_data = 0;
   logic [15:0] p_rb = 0, p_wb = 0;
   logic [31:0] p_rptr, p_wptr, p_lvl;
   logic        p_full, p_empty, p_irq, p_unf, p_ovf;
   logic [30:0] p_pos;

   int checks = 0, fails = 0;
   int c_irq_cnt = 0, p_irq_cnt = 0;
   bit done = 0;

   rbuf_ptr_tracker #(.IS_PLAYBACK(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_sel(c_sel), .cfg_wdata(c_data),
      .mark_rearm(c_rearm), .rd_adv(c_rd), .rd_bytes(c_rb), .wr_adv(c_wr), .wr_bytes(c_wb),
      .rd_ptr(c_rptr), .wr_ptr(c_wptr), .level(c_lvl), .full(c_full), .empty(c_empty),
      .pos_offset(c_pos), .mark_irq(c_irq), .underflow_evt(c_unf), .overflow_evt(c_ovf));

   rbuf_ptr_tracker #(.IS_PLAYBACK(1'b1)) uut_pb (
      .clk(clk), .rst_n(rst_n), .cfg_we(p_we), .cfg_sel(p_sel), .cfg_wdata(p_data),
      .mark_rearm(p_rearm), .rd_adv(p_rd), .rd_bytes(p_rb), .wr_adv(p_wr), .wr_bytes(p_wb),
      .rd_ptr(p_rptr), .wr_ptr(p_wptr), .level(p_lvl), .full(p_full), .empty(p_empty),
      .pos_offset(p_pos), .mark_irq(p_irq), .underflow_evt(p_unf), .overflow_evt(p_ovf));

   always @(posedge clk) begin
      if (c_irq) c_irq_cnt <= c_irq_cnt + 1;
      if (p_irq) p_irq_cnt <= p_irq_cnt + 1;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic c_cfg(input logic [2:0] sel, input logic [31:0] d);
      c_we = 1; c_sel = sel; c_data = d;
      @(negedge clk);
      c_we = 0;
   endtask

   task automatic p_cfg(input logic [2:0] sel, input logic [31:0] d);
      p_we = 1; p_sel = sel; p_data = d;
      @(negedge clk);
      p_we = 0;
   endtask

   task automatic c_adv(input bit rd, input logic [15:0] rb, input bit wr, input logic [15:0] wb);
      c_rd = rd; c_rb = rb; c_wr = wr; c_wb = wb;
      @(negedge clk);
      c_rd = 0; c_wr = 0;
   endtask

   task automatic p_adv(input bit rd, input logic [15:0] rb);
      p_rd = rd; p_rb = rb;
      @(negedge clk);
      p_rd = 0;
   endtask

   task automatic c_rearm_pulse();
      c_rearm = 1; @(negedge clk); c_rearm = 0;
   endtask

   task automatic t_reset();
      check("R11 rd_ptr after reset", c_rptr, 32'h0);
      check("R11 wr_ptr after reset", c_wptr, 32'h0);
      check("R11 empty after reset", {31'b0, c_empty}, 32'h1);
      check("R11 level after reset", c_lvl, 32'h0);
      check("R11 pulses after reset", {29'b0, c_irq, c_unf, c_ovf}, 32'h0);
   endtask

   task automatic t_cap_mark();
      c_cfg(3'd0, 32'h1000); c_cfg(3'd1, 32'h1FFF); c_cfg(3'd2, 32'h200);
      c_cfg(3'd3, 32'h1000); c_cfg(3'd4, 32'h1000);
      idle(3);
      check("R9 disarmed out of reset", c_irq_cnt, 0);
      c_rearm_pulse();
      c_adv(0, 0, 1, 16'h200);
      check("R2 level after write 0x200", c_lvl, 32'h200);
      idle(3);
      check("R7 level equal to mark does not fire", c_irq_cnt, 0);
      c_adv(0, 0, 1, 16'h100);
      idle(3);
      check("R7 level above mark fires once", c_irq_cnt, 1);
      c_adv(0, 0, 1, 16'h100);
      idle(3);
      check("R9 no second pulse while disarmed", c_irq_cnt, 1);
      c_rearm_pulse();
      idle(3);
      check("R9 re-arm fires again", c_irq_cnt, 2);
      check("R10 capture offset uses write pointer", {1'b0, c_pos}, 32'h400);
      c_adv(1, 16'h400, 0, 0);
      check("R1 empty after draining", {31'b0, c_empty}, 32'h1);
      check("R3 rd_ptr after read 0x400", c_rptr, 32'h1400);
      c_adv(1, 16'h1, 0, 0);
      check("R4 underflow pulse", {31'b0, c_unf}, 32'h1);
      check("R4 rd_ptr held", c_rptr, 32'h1400);
      idle(1);
      check("R4 underflow pulse is one cycle", {31'b0, c_unf}, 32'h0);
   endtask

   task automatic t_cap_wrap();
      c_cfg(3'd3, 32'h1F00);
      check("R6 software rd write", c_rptr, 32'h1F00);
      c_cfg(3'd4, 32'h1F00);
      c_cfg(3'd7, 32'h5555);
      check("R6 unused select ignored", c_wptr, 32'h1F00);
      c_adv(0, 0, 1, 16'h200);
      check("R3 wrap toggles bit 31", c_wptr, 32'h8000_1100);
      check("R2 level across wrap", c_lvl, 32'h200);
      c_adv(0, 0, 1, 16'hE00);
      check("R1 full flag", {31'b0, c_full}, 32'h1);
      check("R2 level when full", c_lvl, 32'h1000);
      c_adv(0, 0, 1, 16'h1);
      check("R5 overflow pulse", {31'b0, c_ovf}, 32'h1);
      check("R5 wr_ptr held", c_wptr, 32'h8000_1F00);
      c_adv(1, 16'h1000, 0, 0);
      check("R3 rd wraps to same address", c_rptr, 32'h8000_1F00);
      check("R1 empty after full drain", {31'b0, c_empty}, 32'h1);
   endtask

   task automatic t_cap_priority_gran();
      c_we = 1; c_sel = 3'd4; c_data = 32'h1000; c_wr = 1; c_wb = 16'h10;
      @(negedge clk);
      c_we = 0; c_wr = 0;
      check("R6 pointer write wins over advance", c_wptr, 32'h1000);
      c_cfg(3'd3, 32'h1000);
      c_cfg(3'd2, 32'h1FF);
      c_rearm_pulse();
      idle(2);
      check("R12 no fire at empty", c_irq_cnt, 2);
      c_adv(0, 0, 1, 16'h180);
      idle(3);
      check("R12 mark low bits dropped", c_irq_cnt, 3);
   endtask

   task automatic t_play_mark();
      p_cfg(3'd0, 32'h1000); p_cfg(3'd1, 32'h1FFF); p_cfg(3'd2, 32'h100);
      p_cfg(3'd3, 32'h1000); p_cfg(3'd4, 32'h8000_1000);
      p_rearm = 1; @(negedge clk); p_rearm = 0;
      check("R1 playback starts full", {31'b0, p_full}, 32'h1);
      idle(3);
      check("R8 no fire with zero free", p_irq_cnt, 0);
      p_adv(1, 16'h100);
      idle(3);
      check("R8 free equal to mark does not fire", p_irq_cnt, 0);
      p_adv(1, 16'h100);
      idle(3);
      check("R8 free above mark fires", p_irq_cnt, 1);
      check("R10 playback offset uses read pointer", {1'b0, p_pos}, 32'h200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_cap_mark();
      t_cap_wrap();
      t_cap_priority_gran();
      t_play_mark();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule